// File: doc/BRIEF.md
# Ping-Pong Transfer and Iteration Sequencer

This control block runs a complete reconstruction job inside an accelerator after one start pulse from the host. No further host commands are needed. For every iteration it masters a DMA burst that carries eight projections of data from host memory into one of two staging buffers. It then moves the staged words into the processing engine's input RAM through a copy port, one word per cycle. Once the copy is complete it pulses the engine's start line and waits for the engine's done pulse. A job is 1024 projections, so it takes 128 iterations. When the last one finishes, the block raises its done output.

The two staging buffers are used alternately. The fetch side and the copy side run as separate state machines and share only a pair of occupancy flags. Because of this, the host transfer for block N+1 proceeds while block N is being copied into the input RAM and processed. A fetch waits only when its target buffer still holds data that has not been copied. A copy waits only for its own buffer to fill and for the engine to report done on the previous iteration.

Top module: `pp_iter_seq`

## Requirements
- R1: While `rst` is high at a clock edge the block returns to idle: `done_o`, `dma_req_o`, `cp_en_o` and `eng_start_o` are 0, `iter_o` is 0 and `dma_buf_o` is 0 (buffer A).
- R2: A `go_i` pulse while idle starts a job. In the next cycle `dma_req_o` is 1 with `dma_buf_o` = 0, and every later step is started by the block itself.
- R3: `dma_req_o` stays high until a cycle with `dma_gnt_i` high. After that the block counts `dma_len_o` = `WORDS_PER_PROJ`*8 words, one for each cycle with `dma_vld_i` high. `stg_waddr_o` gives each word's index, 0 upward.
- R4: Data block k is fetched into staging buffer k mod 2 and copied out of that same buffer, where 0 is A and 1 is B.
- R5: `dma_req_o` is never high toward a buffer whose previous block has not been fully copied.
- R6: Once a block's fetch is complete, `cp_en_o` is high for exactly `dma_len_o` consecutive cycles. During those cycles `cp_addr_o` runs 0 upward and `cp_buf_o` names the block's buffer. Blocks are copied in fetch order.
- R7: The copy of block k+1 does not start until `eng_done_i` has been seen for iteration k.
- R8: `eng_start_o` is a one-cycle pulse in the cycle after the last copy word. `eng_done_i` is honoured only while the engine is running.
- R9: A fetch may be requested or in progress while a copy is in progress or the engine is running. A fetch and a copy may finish in the same cycle, and the two always finish on different buffers.
- R10: `iter_o` counts the engine done pulses of the job. After the done pulse for iteration 128, `done_o` goes high in the next cycle with `iter_o` = 128.
- R11: `done_o` stays high until the next `go_i`, and clears in the cycle after that pulse. A `go_i` that arrives during a job has no effect.
- R12: A reset in the middle of a job abandons it. A later `go_i` runs a complete fresh job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Job start pulse from host |
| done_o | output | 1 | Job complete, held until next start |
| dma_req_o | output | 1 | Burst request to the DMA engine |
| dma_buf_o | output | 1 | Staging buffer targeted by the burst (0 = A, 1 = B) |
| dma_len_o | output | LENW | Burst length in words |
| dma_gnt_i | input | 1 | Burst accepted |
| dma_vld_i | input | 1 | One burst word written this cycle |
| stg_waddr_o | output | WAW | Word index within the staging buffer for the current burst word |
| cp_en_o | output | 1 | Copy one word from staging into input RAM this cycle |
| cp_buf_o | output | 1 | Staging buffer being copied |
| cp_addr_o | output | WAW | Word index being copied |
| eng_start_o | output | 1 | Engine start pulse |
| eng_done_i | input | 1 | Engine done pulse |
| iter_o | output | ITW | Completed iterations of the current job |

## Verification
Two events can fall in the same cycle: a fetch completing, which marks a buffer as filled, and a copy completing, which frees the other buffer. The bench varies the grant delay, the data-valid gap pattern and the engine latency from block to block, so the ends of the fetch and the copy sweep past each other across the 128 iterations. It then compares every output, every cycle, with a behavioural model that keeps its own occupancy flags. The same flags judge each request and each copy cycle against R5 and R7, and a count of fetch activity during copy or engine time confirms the overlap.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_XFER = 2'd2,
        F_HOLD = 2'd3
    } fetch_st_e;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_WAIT = 2'd1,
        C_MOVE = 2'd2,
        C_RUN  = 2'd3
    } copy_st_e;

endpackage

// File: rtl/pp_fetch_ctl.sv
module pp_fetch_ctl
    import pp_seq_pkg::*;
#(
    parameter  int BURST    = 32,
    parameter  int NUM_ITER = 128,
    localparam int WAW      = (BURST > 1) ? $clog2(BURST) : 1,
    localparam int BW       = (NUM_ITER > 1) ? $clog2(NUM_ITER) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           job_start_i,
    input  logic [1:0]     buf_full_i,
    input  logic           dma_gnt_i,
    input  logic           dma_vld_i,
    output logic           dma_req_o,
    output logic           dma_buf_o,
    output logic [WAW-1:0] stg_waddr_o,
    output logic           fill_done_o,
    output logic           fill_buf_o
);

    typedef struct packed {
        fetch_st_e      st;
        logic [BW-1:0]  blk;
        logic           sel;
        logic [WAW-1:0] cnt;
    } fetch_t;

    fetch_t q, d;
    logic   fill;

    always_comb begin
        d    = q;
        fill = 1'b0;
        if (job_start_i) begin
            d.st  = F_REQ;
            d.blk = '0;
            d.sel = 1'b0;
            d.cnt = '0;
        end else begin
            case (q.st)
                F_REQ: begin
                    if (dma_gnt_i) begin
                        d.st  = F_XFER;
                        d.cnt = '0;
                    end
                end
                F_XFER: begin
                    if (dma_vld_i) begin
                        if (q.cnt == WAW'(BURST - 1)) begin
                            fill  = 1'b1;
                            d.sel = ~q.sel;
                            d.cnt = '0;
                            d.blk = q.blk + 1'b1;
                            d.st  = (q.blk == BW'(NUM_ITER - 1)) ? F_IDLE : F_HOLD;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                F_HOLD: begin
                    if (!buf_full_i[q.sel]) begin
                        d.st = F_REQ;
                    end
                end
                default: begin
                    d.st = F_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= F_IDLE;
            q.blk <= '0;
            q.sel <= 1'b0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign dma_req_o   = (q.st == F_REQ);
    assign dma_buf_o   = q.sel;
    assign stg_waddr_o = q.cnt;
    assign fill_done_o = fill;
    assign fill_buf_o  = q.sel;

    AST_GNT_LEAVES_REQ: assert property (@(posedge clk) disable iff (rst)
        (dma_req_o && dma_gnt_i && !job_start_i) |=> !dma_req_o); // R3

endmodule

// File: rtl/pp_copy_ctl.sv
module pp_copy_ctl
    import pp_seq_pkg::*;
#(
    parameter  int BURST    = 32,
    parameter  int NUM_ITER = 128,
    localparam int WAW      = (BURST > 1) ? $clog2(BURST) : 1,
    localparam int ITW      = $clog2(NUM_ITER + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           job_start_i,
    input  logic [1:0]     buf_full_i,
    input  logic           eng_done_i,
    output logic           cp_en_o,
    output logic           cp_buf_o,
    output logic [WAW-1:0] cp_addr_o,
    output logic           drain_done_o,
    output logic           drain_buf_o,
    output logic           eng_start_o,
    output logic [ITW-1:0] iter_o,
    output logic           job_end_o
);

    typedef struct packed {
        copy_st_e       st;
        logic           sel;
        logic [WAW-1:0] addr;
        logic           start;
        logic [ITW-1:0] iter;
    } copy_t;

    copy_t q, d;
    logic  drain;
    logic  fin;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        drain   = 1'b0;
        fin     = 1'b0;
        if (job_start_i) begin
            d.st   = C_WAIT;
            d.sel  = 1'b0;
            d.addr = '0;
            d.iter = '0;
        end else begin
            case (q.st)
                C_WAIT: begin
                    if (buf_full_i[q.sel]) begin
                        d.st   = C_MOVE;
                        d.addr = '0;
                    end
                end
                C_MOVE: begin
                    if (q.addr == WAW'(BURST - 1)) begin
                        drain   = 1'b1;
                        d.sel   = ~q.sel;
                        d.addr  = '0;
                        d.start = 1'b1;
                        d.st    = C_RUN;
                    end else begin
                        d.addr = q.addr + 1'b1;
                    end
                end
                C_RUN: begin
                    if (eng_done_i && !q.start) begin
                        d.iter = q.iter + 1'b1;
                        if (q.iter == ITW'(NUM_ITER - 1)) begin
                            fin  = 1'b1;
                            d.st = C_IDLE;
                        end else begin
                            d.st = C_WAIT;
                        end
                    end
                end
                default: begin
                    d.st = C_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= C_IDLE;
            q.sel   <= 1'b0;
            q.addr  <= '0;
            q.start <= 1'b0;
            q.iter  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cp_en_o      = (q.st == C_MOVE);
    assign cp_buf_o     = q.sel;
    assign cp_addr_o    = q.addr;
    assign drain_done_o = drain;
    assign drain_buf_o  = q.sel;
    assign eng_start_o  = q.start;
    assign iter_o       = q.iter;
    assign job_end_o    = fin;

    AST_START_AFTER_COPY: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |-> $past(cp_en_o)); // R8

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |=> !eng_start_o); // R8

endmodule

// File: rtl/pp_iter_seq.sv
module pp_iter_seq
    import pp_seq_pkg::*;
#(
    parameter  int WORDS_PER_PROJ = 4,
    parameter  int PROJ_PER_ITER  = 8,
    parameter  int NUM_ITER       = 128,
    localparam int BURST          = WORDS_PER_PROJ * PROJ_PER_ITER,
    localparam int WAW            = (BURST > 1) ? $clog2(BURST) : 1,
    localparam int LENW           = $clog2(BURST + 1),
    localparam int ITW            = $clog2(NUM_ITER + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go_i,
    output logic            done_o,
    output logic            dma_req_o,
    output logic            dma_buf_o,
    output logic [LENW-1:0] dma_len_o,
    input  logic            dma_gnt_i,
    input  logic            dma_vld_i,
    output logic [WAW-1:0]  stg_waddr_o,
    output logic            cp_en_o,
    output logic            cp_buf_o,
    output logic [WAW-1:0]  cp_addr_o,
    output logic            eng_start_o,
    input  logic            eng_done_i,
    output logic [ITW-1:0]  iter_o
);

    typedef struct packed {
        logic       run;
        logic       done;
        logic [1:0] full;
    } job_t;

    job_t q, d;
    logic job_start;
    logic fill_done, fill_buf;
    logic drain_done, drain_buf;
    logic job_end;

    assign job_start = go_i && !q.run;

    pp_fetch_ctl #(
        .BURST    (BURST),
        .NUM_ITER (NUM_ITER)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .job_start_i (job_start),
        .buf_full_i  (q.full),
        .dma_gnt_i   (dma_gnt_i),
        .dma_vld_i   (dma_vld_i),
        .dma_req_o   (dma_req_o),
        .dma_buf_o   (dma_buf_o),
        .stg_waddr_o (stg_waddr_o),
        .fill_done_o (fill_done),
        .fill_buf_o  (fill_buf)
    );

    pp_copy_ctl #(
        .BURST    (BURST),
        .NUM_ITER (NUM_ITER)
    ) u_copy (
        .clk          (clk),
        .rst          (rst),
        .job_start_i  (job_start),
        .buf_full_i   (q.full),
        .eng_done_i   (eng_done_i),
        .cp_en_o      (cp_en_o),
        .cp_buf_o     (cp_buf_o),
        .cp_addr_o    (cp_addr_o),
        .drain_done_o (drain_done),
        .drain_buf_o  (drain_buf),
        .eng_start_o  (eng_start_o),
        .iter_o       (iter_o),
        .job_end_o    (job_end)
    );

    always_comb begin
        d = q;
        if (job_start) begin
            d.run  = 1'b1;
            d.done = 1'b0;
            d.full = 2'b00;
        end else begin
            if (fill_done) begin
                d.full[fill_buf] = 1'b1;
            end
            if (drain_done) begin
                d.full[drain_buf] = 1'b0;
            end
            if (job_end) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.run  <= 1'b0;
            q.done <= 1'b0;
            q.full <= 2'b00;
        end else begin
            q <= d;
        end
    end

    assign done_o    = q.done;
    assign dma_len_o = LENW'(BURST);

    // Engine activity as seen at the ports, kept only for the checks below.
    logic eng_busy_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            eng_busy_q <= 1'b0;
        end else if (eng_start_o) begin
            eng_busy_q <= 1'b1;
        end else if (eng_done_i) begin
            eng_busy_q <= 1'b0;
        end
    end

    AST_REQ_FREE_BUF: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> !q.full[dma_buf_o]); // R5

    AST_COPY_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        cp_en_o |-> q.full[cp_buf_o]); // R6

    AST_COPY_ENG_IDLE: assert property (@(posedge clk) disable iff (rst)
        cp_en_o |-> !eng_busy_q); // R7

    AST_SPLIT_BUFFERS: assert property (@(posedge clk) disable iff (rst)
        (fill_done && drain_done) |-> (fill_buf != drain_buf)); // R9

    AST_ITER_LIMIT: assert property (@(posedge clk) disable iff (rst)
        iter_o <= ITW'(NUM_ITER)); // R10

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !go_i) |=> done_o); // R11

    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (go_i && q.run) |=> (iter_o >= $past(iter_o))); // R11

endmodule

// File: tb/pp_iter_seq_tb.sv
`timescale 1ns/1ps
module pp_iter_seq_tb;

    localparam int WPP   = 4;
    localparam int PPI   = 8;
    localparam int NIT   = 128;
    localparam int BURST = WPP * PPI;
    localparam int WAW   = $clog2(BURST);
    localparam int LENW  = $clog2(BURST + 1);
    localparam int ITW   = $clog2(NIT + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go  = 1'b0;
    logic dma_gnt = 1'b0;
    logic dma_vld = 1'b0;
    logic eng_done = 1'b0;

    logic            done_o, dma_req_o, dma_buf_o, cp_en_o, cp_buf_o, eng_start_o;
    logic [LENW-1:0] dma_len_o;
    logic [WAW-1:0]  stg_waddr_o, cp_addr_o;
    logic [ITW-1:0]  iter_o;

    always #2.5 clk = ~clk;

    pp_iter_seq #(.WORDS_PER_PROJ(WPP), .PROJ_PER_ITER(PPI), .NUM_ITER(NIT)) u_dut (
        .clk(clk), .rst(rst), .go_i(go), .done_o(done_o),
        .dma_req_o(dma_req_o), .dma_buf_o(dma_buf_o), .dma_len_o(dma_len_o),
        .dma_gnt_i(dma_gnt), .dma_vld_i(dma_vld), .stg_waddr_o(stg_waddr_o),
        .cp_en_o(cp_en_o), .cp_buf_o(cp_buf_o), .cp_addr_o(cp_addr_o),
        .eng_start_o(eng_start_o), .eng_done_i(eng_done), .iter_o(iter_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Behavioural model: phases 0 idle, 1 request, 2 transfer, 3 hold (fetch);
    // 0 idle, 1 wait, 2 move, 3 run (copy).
    int m_f = 0, m_blk = 0, m_fsel = 0, m_wc = 0;
    int m_c = 0, m_csel = 0, m_ca = 0, m_it = 0;
    bit m_st = 0, m_run = 0, m_done = 0, m_busy = 0;
    bit [1:0] m_full = 2'b00;
    bit e_go, e_fill, e_drain, e_fin, e_stn;
    int e_fb, e_db;
    int n_coinc = 0, n_overlap = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_f = 0; m_blk = 0; m_fsel = 0; m_wc = 0;
            m_c = 0; m_csel = 0; m_ca = 0; m_it = 0;
            m_st = 0; m_run = 0; m_done = 0; m_busy = 0; m_full = 2'b00;
        end else begin
            e_go    = go && !m_run;
            e_fill  = (m_f == 2) && dma_vld && (m_wc == BURST - 1);
            e_fb    = m_fsel;
            e_drain = (m_c == 2) && (m_ca == BURST - 1);
            e_db    = m_csel;
            e_fin   = (m_c == 3) && !m_st && eng_done && (m_it == NIT - 1);
            if (e_fill && e_drain) n_coinc++;
            if ((m_f == 1 || m_f == 2) && (m_c == 2 || m_busy)) n_overlap++;
            if (m_st) m_busy = 1; else if (eng_done) m_busy = 0;
            if (e_go) begin
                m_f = 1; m_blk = 0; m_fsel = 0; m_wc = 0;
            end else if (m_f == 1) begin
                if (dma_gnt) begin m_f = 2; m_wc = 0; end
            end else if (m_f == 2) begin
                if (e_fill) begin
                    m_fsel ^= 1; m_wc = 0;
                    m_f = (m_blk == NIT - 1) ? 0 : 3;
                    m_blk++;
                end else if (dma_vld) m_wc++;
            end else if (m_f == 3) begin
                if (!m_full[m_fsel]) m_f = 1;
            end
            e_stn = 0;
            if (e_go) begin
                m_c = 1; m_csel = 0; m_ca = 0; m_it = 0;
            end else if (m_c == 1) begin
                if (m_full[m_csel]) begin m_c = 2; m_ca = 0; end
            end else if (m_c == 2) begin
                if (e_drain) begin m_csel ^= 1; m_ca = 0; e_stn = 1; m_c = 3; end
                else m_ca++;
            end else if (m_c == 3) begin
                if (eng_done && !m_st) begin m_it++; m_c = e_fin ? 0 : 1; end
            end
            m_st = e_stn;
            if (e_go) begin
                m_run = 1; m_done = 0; m_full = 2'b00;
            end else begin
                if (e_fill) m_full[e_fb] = 1;
                if (e_drain) m_full[e_db] = 0;
                if (e_fin) begin m_run = 0; m_done = 1; end
            end
        end
    end

    // Per-cycle comparison and DMA / engine responders, on the falling edge.
    bit xfer = 0, ebusy = 0;
    int sent = 0, gwait = 0, blkcnt = 0, ecnt = 0, ecount = 0;

    always @(negedge clk) begin
        chk("R3 dma_req_o", dma_req_o, (m_f == 1));
        chk("R4 dma_buf_o", dma_buf_o, m_fsel);
        chk("R3 stg_waddr_o", stg_waddr_o, m_wc);
        chk("R3 dma_len_o", dma_len_o, BURST);
        chk("R6 cp_en_o", cp_en_o, (m_c == 2));
        chk("R4 cp_buf_o", cp_buf_o, m_csel);
        chk("R6 cp_addr_o", cp_addr_o, m_ca);
        chk("R8 eng_start_o", eng_start_o, m_st);
        chk("R10 iter_o", iter_o, m_it);
        chk("R11 done_o", done_o, m_done);
        if (dma_req_o) chk("R5 target buffer free", m_full[dma_buf_o], 0);
        if (cp_en_o) chk("R7 engine idle during copy", m_busy, 0);

        dma_gnt = 0; dma_vld = 0; eng_done = 0;
        if (rst) begin
            xfer = 0; sent = 0; gwait = 0; ebusy = 0; ecnt = 0;
        end else begin
            if (xfer) begin
                if ((blkcnt % 3) == 0 || (cyc % 3) != 0) begin
                    dma_vld = 1; sent++;
                    if (sent == BURST) xfer = 0;
                end
            end else if (dma_req_o) begin
                if (gwait >= (blkcnt % 4)) begin
                    dma_gnt = 1; xfer = 1; sent = 0; gwait = 0; blkcnt++;
                end else gwait++;
            end
            if (ebusy) begin
                if (ecnt == 0) begin eng_done = 1; ebusy = 0; end
                else ecnt--;
            end else if (eng_start_o) begin
                ebusy = 1; ecnt = (ecount * 13) % 45; ecount++;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected at most 150000", cyc);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (4) tick();
        chk("R1 done_o", done_o, 0);
        chk("R1 dma_req_o", dma_req_o, 0);
        chk("R1 cp_en_o", cp_en_o, 0);
        chk("R1 eng_start_o", eng_start_o, 0);
        chk("R1 iter_o", iter_o, 0);
        chk("R1 dma_buf_o", dma_buf_o, 0);
        rst = 0;
        tick();
        go = 1; tick(); go = 0;
        chk("R2 request after go", dma_req_o, 1);
        chk("R2 first buffer A", dma_buf_o, 0);

        repeat (600) tick();
        go = 1; tick(); go = 0;   // R11: ignored during the job
        wait (done_o == 1'b1);
        tick();
        chk("R10 final count", iter_o, NIT);
        repeat (30) tick();
        chk("R11 done held", done_o, 1);
        chk("R9 fetch overlapped copy or engine", (n_overlap > 0), 1);
        $display("info: fetch and copy finished together in %0d cycles", n_coinc);

        go = 1; tick(); go = 0;
        chk("R11 done cleared by go", done_o, 0);
        wait (iter_o == ITW'(40));
        tick();
        rst = 1; tick(); rst = 0;
        chk("R12 req after abort", dma_req_o, 0);
        chk("R12 copy after abort", cp_en_o, 0);
        chk("R12 iter after abort", iter_o, 0);
        chk("R12 done after abort", done_o, 0);
        chk("R12 buffer after abort", dma_buf_o, 0);
        chk("R12 start after abort", eng_start_o, 0);
        repeat (5) tick();
        go = 1; tick(); go = 0;
        wait (done_o == 1'b1);
        tick();
        chk("R12 fresh job completes", iter_o, NIT);
        repeat (10) tick();
        finish_run();
    end

endmodule